// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller with Poll Readback

The block gathers eight level-sensitive request inputs and passes each through a two-flop synchronizer into a sticky pending register. A fixed priority scheme picks the winning level. Level 0 wins and level 7 loses. A pending level is serviceable only when no level of the same or higher priority is already marked as in service. The interrupt output stays high for as long as a serviceable level exists.

The host talks to the block over a small register bus with a two-bit address. An acknowledge strobe moves the winning level from pending to in service. A non-specific end-of-interrupt command retires the highest-priority in-service level.

A control word chooses which status register a read returns. It can also arm a poll. The next read after arming, at any address, returns a status byte that holds a pending flag and the encoded winning level. That read also counts as the acknowledge for the level it reports.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset, the pending and in-service registers are zero, `int_out` is low, no poll is armed, and a read returns the pending register.
- R2: A request input is captured through two synchronizer flops and then the pending register. A level driven before a clock edge shows in the pending register, and on `int_out`, after the third rising edge. It does not show after the second.
- R3: `int_out` is high exactly when the lowest-numbered pending bit is below the lowest-numbered in-service bit, or when some bit is pending and nothing is in service.
- R4: An `int_ack` pulse while `int_out` is high clears the lowest-numbered pending bit and sets the same bit in service. An `int_ack` pulse while `int_out` is low changes nothing.
- R5: A write of a byte with bit 3 = 0 and bit 5 = 1 to address 0 is an end-of-interrupt command. It clears the lowest-numbered set in-service bit. The in-service register changes only on an acknowledge, a poll read or this command.
- R6: A write to address 0 with bit 3 = 1 is a control word. If bit 1 = 1, bit 0 picks the readback: 0 returns the pending register and 1 returns the in-service register. If bit 1 = 0, the readback choice is kept. Bit 2 = 1 arms a poll and bit 2 = 0 disarms it.
- R7: A poll status byte has bit 7 equal to `int_out`, bits 6 to 3 at zero, and bits 2 to 0 holding the winning level number. Bits 2 to 0 read zero when bit 7 is 0.
- R8: A poll read acknowledges the reported level as in R4 and disarms the poll. Later reads return the selected register.
- R9: An armed poll answers a read at any of the four addresses.
- R10: Writes to addresses 1, 2 and 3 have no effect on any register or selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| irq_in | input | 8 | Level request inputs, bit n is level n |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| int_out | output | 1 | Interrupt request to the host |

## Verification
A request level driven at a falling edge reaches `int_out` after the third rising edge. The bench checks the output at the falling edge after the second rising edge and again after the third. Read data is combinational from registered state, so the bench samples it during the strobe cycle, before the edge that applies a poll read's side effects. The effects of an acknowledge, a command write or a poll read land on the rising edge inside the strobe, so the bench looks at them only with a later read.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  // control / command byte bit positions
  localparam int CW_TAG_BIT  = 3;  // 1: control word, 0: command
  localparam int CW_POLL_BIT = 2;  // arm poll
  localparam int CW_LOAD_BIT = 1;  // update readback selection
  localparam int CW_SEL_BIT  = 0;  // readback selection value
  localparam int EOI_BIT     = 5;  // non-specific end of interrupt
  localparam int PB_FLAG_BIT = 7;  // poll byte pending flag
  localparam int BUS_W       = 8;

  typedef enum logic {SEL_PEND = 1'b0, SEL_SERV = 1'b1} rb_sel_e;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [LW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // lowest index wins
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) begin
        idx    = LW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
    any = |vec;
  end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             int_ack,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             int_out
);
  localparam int LVL_W = $clog2(N_IRQ);

  logic             rst_ns;
  logic [N_IRQ-1:0] irq_s;
  logic [N_IRQ-1:0] irr_q, irr_d, isr_q, isr_d;
  rb_sel_e          sel_q, sel_d;
  logic             poll_q, poll_d;
  logic             irr_any, isr_any;
  logic [LVL_W-1:0] req_idx, isr_idx;
  logic [N_IRQ-1:0] req_oh, isr_oh;
  logic             svc, cmd_wr, ctl_wr, eoi_wr, host_rd, poll_rd, ack_fire;
  logic [N_IRQ-1:0] ack_mask, eoi_mask;
  logic [BUS_W-1:0] poll_byte;

  // reset release synchronizer
  req_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns));

  req_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_ns), .d(irq_in), .q(irq_s));

  prio_pick #(.N(N_IRQ)) u_pend_pick (
    .vec(irr_q), .any(irr_any), .idx(req_idx), .onehot(req_oh));

  prio_pick #(.N(N_IRQ)) u_serv_pick (
    .vec(isr_q), .any(isr_any), .idx(isr_idx), .onehot(isr_oh));

  always_comb begin
    svc      = irr_any && (!isr_any || (req_idx < isr_idx));
    cmd_wr   = bus_sel && bus_wr && (bus_addr == 2'd0);
    ctl_wr   = cmd_wr && bus_wdata[CW_TAG_BIT];
    eoi_wr   = cmd_wr && !bus_wdata[CW_TAG_BIT] && bus_wdata[EOI_BIT];
    host_rd  = bus_sel && bus_rd;
    poll_rd  = host_rd && poll_q;
    ack_fire = (int_ack || poll_rd) && svc;
    ack_mask = ack_fire ? req_oh : '0;
    eoi_mask = eoi_wr ? isr_oh : '0;

    irr_d = (irr_q | irq_s) & ~ack_mask;
    isr_d = (isr_q | ack_mask) & ~eoi_mask;

    poll_d = poll_q;
    if (ctl_wr)       poll_d = bus_wdata[CW_POLL_BIT];
    else if (poll_rd) poll_d = 1'b0;

    sel_d = sel_q;
    if (ctl_wr && bus_wdata[CW_LOAD_BIT])
      sel_d = bus_wdata[CW_SEL_BIT] ? SEL_SERV : SEL_PEND;

    poll_byte = '0;
    poll_byte[PB_FLAG_BIT] = svc;
    if (svc) poll_byte[LVL_W-1:0] = req_idx;

    bus_rdata = '0;
    if (host_rd) begin
      if (poll_q)                bus_rdata = poll_byte;
      else if (sel_q == SEL_SERV) bus_rdata = BUS_W'(isr_q);
      else                        bus_rdata = BUS_W'(irr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      irr_q  <= '0;
      isr_q  <= '0;
      sel_q  <= SEL_PEND;
      poll_q <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      sel_q  <= sel_d;
      poll_q <= poll_d;
    end
  end

  assign int_out = svc;
endmodule

// File: rtl/irq_poll_ctrl_chk.sv
module irq_poll_ctrl_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_ack,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             int_out,
  input logic [N_IRQ-1:0] irr_q,
  input logic [N_IRQ-1:0] isr_q,
  input logic             poll_q
);
  logic any_rd, any_wr, eoi_cmd;
  assign any_rd  = bus_sel && bus_rd;
  assign any_wr  = bus_sel && bus_wr;
  assign eoi_cmd = any_wr && (bus_addr == 2'd0) && !bus_wdata[3] && bus_wdata[5];

  assert_int_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q != '0));

  assert_ack_grows_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !any_wr) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  assert_eoi_shrinks_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !int_ack && !any_rd && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_isr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_ack && !any_rd && !any_wr) |=> $stable(isr_q));

  assert_poll_byte_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd && poll_q) |-> ((bus_rdata[6:3] == 4'd0) && (bus_rdata[7] == int_out)));

  assert_poll_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd && poll_q && !any_wr) |=> !poll_q);
endmodule

bind irq_poll_ctrl irq_poll_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_out(int_out),
  .irr_q(irr_q), .isr_q(isr_q), .poll_q(poll_q));

// File: tb/irq_poll_ctrl_tb.sv
module irq_poll_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       int_ack, bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       int_out;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_ack(int_ack),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_out(int_out));

  // {request pattern, expected poll byte}
  localparam logic [15:0] VEC [7] = '{
    16'h00_00, 16'h01_80, 16'h80_87, 16'h06_81,
    16'h30_84, 16'hFF_80, 16'h48_83};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; int_ack = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    do_reset();
    // R1 reset state
    check("R1 int", {7'd0, int_out}, 8'h00);
    bus_read(2'd0, rd); check("R1 pend", rd, 8'h00);
    bus_write(2'd0, 8'h0B);
    bus_read(2'd0, rd); check("R1 serv", rd, 8'h00);

    // table: poll at each address (R7, R8, R9)
    for (int i = 0; i < 7; i++) begin
      logic [7:0] pat, exp_serv;
      pat = VEC[i][15:8];
      exp_serv = pat & (~pat + 8'd1);
      do_reset();
      drive_irq(pat);
      check("R3 int", {7'd0, int_out}, {7'd0, pat != 0});
      bus_write(2'd0, 8'h0C);
      bus_read(2'(i % 4), rd); check("R7 R9 poll byte", rd, VEC[i][7:0]);
      bus_write(2'd0, 8'h0B);
      bus_read(2'd0, rd); check("R8 poll ack serv", rd, exp_serv);
    end

    // R2 latency
    do_reset();
    @(negedge clk); irq_in = 8'h08;
    repeat (2) @(posedge clk);
    @(negedge clk); check("R2 two edges", {7'd0, int_out}, 8'h00);
    @(negedge clk); check("R2 three edges", {7'd0, int_out}, 8'h01);

    // R4 acknowledge, R3 blocking
    do_reset();
    drive_irq(8'h14);
    drive_irq(8'h00);
    pulse_ack();
    bus_read(2'd0, rd); check("R4 pend", rd, 8'h10);
    bus_write(2'd0, 8'h0B);
    bus_read(2'd0, rd); check("R4 serv", rd, 8'h04);
    check("R3 blocked", {7'd0, int_out}, 8'h00);
    pulse_ack();
    bus_read(2'd0, rd); check("R4 ack no effect", rd, 8'h04);
    drive_irq(8'h01);
    drive_irq(8'h00);
    check("R3 preempt", {7'd0, int_out}, 8'h01);
    pulse_ack();
    bus_read(2'd0, rd); check("R4 nested", rd, 8'h05);

    // R10 writes elsewhere ignored
    bus_write(2'd3, 8'h20);
    bus_read(2'd0, rd); check("R10 eoi at addr3", rd, 8'h05);
    bus_write(2'd1, 8'h0A);
    bus_read(2'd0, rd); check("R10 sel at addr1", rd, 8'h05);
    bus_write(2'd2, 8'h0C);
    bus_read(2'd0, rd); check("R10 poll at addr2", rd, 8'h05);

    // R5 end of interrupt
    bus_write(2'd0, 8'h20);
    bus_read(2'd0, rd); check("R5 eoi1", rd, 8'h04);
    check("R3 still blocked", {7'd0, int_out}, 8'h00);
    bus_write(2'd0, 8'h20);
    bus_read(2'd0, rd); check("R5 eoi2", rd, 8'h00);
    check("R3 unblocked", {7'd0, int_out}, 8'h01);

    // R6 selection kept without load bit, then switched
    bus_write(2'd0, 8'h09);
    bus_read(2'd0, rd); check("R6 keep", rd, 8'h00);
    bus_write(2'd0, 8'h0A);
    bus_read(2'd0, rd); check("R6 pend", rd, 8'h10);

    // R8 poll disarms, R6 poll cancel
    bus_write(2'd0, 8'h0C);
    bus_read(2'd1, rd); check("R8 poll", rd, 8'h84);
    bus_read(2'd0, rd); check("R8 disarmed", rd, 8'h00);
    drive_irq(8'h40); drive_irq(8'h00);
    bus_write(2'd0, 8'h0C);
    bus_write(2'd0, 8'h08);
    bus_read(2'd0, rd); check("R6 poll cancel", rd, 8'h40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule